// File: doc/BRIEF.md
# Move-Driven Integer Function Unit

This block is an integer arithmetic unit for a processor whose instructions are data moves. It has no opcode input. A move to the operand port only stores a value. A move to the trigger port stores the second value and, through the trigger address, picks the operation and starts it. The operation runs through one internal pipeline stage. The outcome then lands in a result register, where it stays until a later move reads it.

The unit supports addition, subtraction and equality compare. A compare leaves a single bit, zero-extended, so that a later move can carry it into a boolean guard register. The result register drives the result port directly, so the interconnect can route it straight into the operand port of another unit without passing through a register file.

Top module: `tt_int_fu`

## Requirements
- R1: After reset the result port reads zero and `res_valid` is low.
- R2: A write to the operand port (`opd_we`) without a trigger write leaves the result and `res_valid` unchanged. It only stores the value for later use.
- R3: A trigger write with `trg_sel` = 0 writes (operand + trigger) modulo 2^WIDTH to the result register 2 cycles after the trigger edge.
- R4: A trigger write with `trg_sel` = 1 writes (operand − trigger) modulo 2^WIDTH to the result register 2 cycles after the trigger edge.
- R5: A trigger write with `trg_sel` = 2 writes 1 if operand equals trigger and 0 otherwise. Bits above bit 0 are zero.
- R6: When the operand and the trigger are written in the same cycle, the operation uses the new operand.
- R7: The result register keeps its value until the next operation completes. `res_valid` goes high with the first completed operation and stays high until reset.
- R8: Trigger writes on consecutive cycles each produce their own result, in order, one per cycle.
- R9: A trigger write with `trg_sel` = 3 is treated as add.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| opd_we | input | 1 | Operand port write strobe |
| opd_data | input | WIDTH | Operand value |
| trg_we | input | 1 | Trigger port write strobe; starts an operation |
| trg_sel | input | 2 | Trigger address selecting the operation |
| trg_data | input | WIDTH | Trigger (second) operand value |
| res_data | output | WIDTH | Result register contents |
| res_valid | output | 1 | High once any result has landed |

## Verification
The bench builds the unit with WIDTH = 8. At that width the carry-out and borrow cases can be reached with small directed values: 0xFF + 0x01 wraps to 0x00, and 0x00 − 0x01 gives 0xFF. The 8-bit width also lets the bench hit exact compare matches and near misses that differ only in the top bit. Back-to-back triggers and same-cycle operand-plus-trigger writes check the two-cycle latency and the operand forwarding at that width.

// File: rtl/tt_fu_pkg.sv
package tt_fu_pkg;
  typedef enum logic [1:0] {
    FU_ADD  = 2'd0,
    FU_SUB  = 2'd1,
    FU_CMPEQ = 2'd2,
    FU_RSVD = 2'd3
  } fu_op_e;

  function automatic logic [63:0] fu_compute(input fu_op_e op,
                                             input logic [63:0] a,
                                             input logic [63:0] b,
                                             input int unsigned w);
    logic [63:0] mask;
    logic [63:0] r;
    mask = (w >= 64) ? '1 : ((64'd1 << w) - 64'd1);
    unique case (op)
      FU_SUB:   r = (a - b) & mask;
      FU_CMPEQ: r = ((a & mask) == (b & mask)) ? 64'd1 : 64'd0;
      default:  r = (a + b) & mask;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/tt_fu_latch.sv
module tt_fu_latch
  import tt_fu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             opd_we,
  input  logic [WIDTH-1:0] opd_data,
  input  logic             trg_we,
  input  logic [1:0]       trg_sel,
  input  logic [WIDTH-1:0] trg_data,
  output logic             s1_fire,
  output fu_op_e           s1_op,
  output logic [WIDTH-1:0] s1_a,
  output logic [WIDTH-1:0] s1_b
);
  logic [WIDTH-1:0] opd_q;
  logic [WIDTH-1:0] opd_eff;

  // forward a same-cycle operand write into the triggered operation
  assign opd_eff = opd_we ? opd_data : opd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opd_q   <= '0;
      s1_fire <= 1'b0;
      s1_op   <= FU_ADD;
      s1_a    <= '0;
      s1_b    <= '0;
    end else begin
      if (opd_we) opd_q <= opd_data;
      s1_fire <= trg_we;
      if (trg_we) begin
        s1_op <= fu_op_e'(trg_sel);
        s1_a  <= opd_eff;
        s1_b  <= trg_data;
      end
    end
  end

  assert_opd_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !opd_we |=> opd_q == $past(opd_q));
  assert_fwd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (trg_we && opd_we) |=> s1_a == $past(opd_data));
endmodule

// File: rtl/tt_fu_exec.sv
module tt_fu_exec
  import tt_fu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s1_fire,
  input  fu_op_e           s1_op,
  input  logic [WIDTH-1:0] s1_a,
  input  logic [WIDTH-1:0] s1_b,
  output logic             done,
  output logic [WIDTH-1:0] res_q,
  output logic             valid_q
);
  logic [63:0]      wide;
  logic [WIDTH-1:0] res_d;

  always_comb begin
    wide  = fu_compute(s1_op, 64'(s1_a), 64'(s1_b), WIDTH);
    res_d = wide[WIDTH-1:0];
  end

  assign done = s1_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q   <= '0;
      valid_q <= 1'b0;
    end else if (s1_fire) begin
      res_q   <= res_d;
      valid_q <= 1'b1;
    end
  end

  assert_res_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(res_q));
  assert_valid_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> valid_q);
  assert_cmp_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && s1_op == FU_CMPEQ) |=> (res_q >> 1) == '0);
endmodule

// File: rtl/tt_int_fu.sv
module tt_int_fu
  import tt_fu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             opd_we,
  input  logic [WIDTH-1:0] opd_data,
  input  logic             trg_we,
  input  logic [1:0]       trg_sel,
  input  logic [WIDTH-1:0] trg_data,
  output logic [WIDTH-1:0] res_data,
  output logic             res_valid
);
  logic             s1_fire;
  fu_op_e           s1_op;
  logic [WIDTH-1:0] s1_a;
  logic [WIDTH-1:0] s1_b;
  logic             done;

  tt_fu_latch #(.WIDTH(WIDTH)) u_latch (
    .clk(clk), .rst_n(rst_n), .opd_we(opd_we), .opd_data(opd_data),
    .trg_we(trg_we), .trg_sel(trg_sel), .trg_data(trg_data),
    .s1_fire(s1_fire), .s1_op(s1_op), .s1_a(s1_a), .s1_b(s1_b));

  tt_fu_exec #(.WIDTH(WIDTH)) u_exec (
    .clk(clk), .rst_n(rst_n), .s1_fire(s1_fire), .s1_op(s1_op),
    .s1_a(s1_a), .s1_b(s1_b), .done(done), .res_q(res_data),
    .valid_q(res_valid));

  assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    trg_we |=> done);
  assert_no_trig_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!trg_we && !s1_fire) |=> ##1 $stable(res_data));
  assert_reset_R1: assert property (@(posedge clk)
    !res_valid |-> res_data == '0);
endmodule

// File: tb/tb_tt_int_fu.sv
module tb_tt_int_fu;
  localparam int W = 8;
  logic clk = 0, rst_n = 0;
  logic opd_we = 0, trg_we = 0;
  logic [W-1:0] opd_data = 0, trg_data = 0;
  logic [1:0] trg_sel = 0;
  logic [W-1:0] res_data;
  logic res_valid;
  int checks = 0, fails = 0;

  tt_int_fu #(.WIDTH(W)) dut (.*);

  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive on negedge, pulse one cycle
  task automatic move(input bit ow, input logic [W-1:0] od, input bit tw,
                      input logic [1:0] sel, input logic [W-1:0] td);
    @(negedge clk);
    opd_we = ow; opd_data = od; trg_we = tw; trg_sel = sel; trg_data = td;
    @(negedge clk);
    opd_we = 0; trg_we = 0;
  endtask

  // one op: operand move then trigger move; result readable 2 edges after trigger
  task automatic run_op(input string req, input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic [1:0] sel, input logic [W-1:0] exp);
    move(1, a, 0, 0, 0);
    move(0, 0, 1, sel, b);  // now 1 edge after trigger
    @(negedge clk);         // 2 edges after trigger
    chk(req, res_data, exp);
  endtask

  task automatic t_reset();
    chk("R1", res_data, 0);
    chk("R1", {7'd0, res_valid}, 0);
  endtask

  task automatic t_operand_only();
    move(1, 8'h55, 0, 0, 0);
    @(negedge clk); @(negedge clk);
    chk("R2", res_data, 0);
    chk("R2", {7'd0, res_valid}, 0);
  endtask

  task automatic t_arith();
    run_op("R3", 8'h12, 8'h34, 0, 8'h46);
    chk("R7", {7'd0, res_valid}, 1);
    run_op("R3", 8'hFF, 8'h01, 0, 8'h00);
    run_op("R4", 8'h50, 8'h20, 1, 8'h30);
    run_op("R4", 8'h00, 8'h01, 1, 8'hFF);
    run_op("R5", 8'hA5, 8'hA5, 2, 8'h01);
    run_op("R5", 8'h25, 8'hA5, 2, 8'h00);
    run_op("R9", 8'h10, 8'h07, 3, 8'h17);
  endtask

  task automatic t_hold();
    // result 0x17 held; operand move alone must not change it
    move(1, 8'h99, 0, 0, 0);
    repeat (3) @(negedge clk);
    chk("R7", res_data, 8'h17);
    chk("R2", res_data, 8'h17);
    // the stored operand 0x99 is used by a later trigger
    move(0, 0, 1, 0, 8'h01);
    @(negedge clk);
    chk("R2", res_data, 8'h9A);
  endtask

  task automatic t_same_cycle();
    move(1, 8'h01, 0, 0, 0);
    move(1, 8'h40, 1, 0, 8'h02);
    @(negedge clk);
    chk("R6", res_data, 8'h42);
  endtask

  task automatic t_back_to_back();
    move(1, 8'h10, 0, 0, 0);
    @(negedge clk);
    trg_we = 1; trg_sel = 0; trg_data = 8'h01;  // trigger A at next edge
    @(negedge clk);
    trg_sel = 1; trg_data = 8'h03;              // trigger B
    @(negedge clk);
    trg_we = 0;
    chk("R8", res_data, 8'h11);                 // A: 2 edges after its trigger
    @(negedge clk);
    chk("R8", res_data, 8'h0D);                 // B
  endtask

  initial begin : wd
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_operand_only();
    t_arith();
    t_hold();
    t_same_cycle();
    t_back_to_back();
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule